// File: doc/BRIEF.md
# Framer Alarm Interrupt Collector

This block gathers alarm and event indications from a T1 receive and transmit framer into two 8-bit interrupt words. Four sources are level conditions: terminal frame sync, multiframe sync, all-ones (AIS) and loss of signal. Their bits latch whenever the condition changes, in either direction. The other sources are single-cycle event pulses, such as framing bit errors, CRC-6 errors, bipolar violations, slips and PRBS errors. Each pulse latches its bit on its own.

Each bit has an enable. A bit can only latch while its enable is high. Clearing an enable hides a latched bit from the interrupt output but does not clear it. The interrupt output is the OR of every latched bit whose enable is set. A read port returns either word. Reading a word clears that word on the same clock edge and leaves the other word untouched.

Top module: `framer_irq_regs`

## Requirements
- R1: While `rst_n` is low and after it is released, both words hold zero, `irq_o` is 0 and the change-detect history holds 0. A level input that is high on the first clock after reset therefore counts as a change.
- R2: Word zero bit 7 latches on any change of `term_sync_i`. Bit 6 latches on a change of `mfrm_sync_i`, bit 4 on a change of `ais_i` and bit 3 on a change of `los_i`. Rising and falling changes both count. The bit is readable after the clock edge that first samples the new level.
- R3: Word zero bit 5 latches on a pulse of `yellow_ev_i`. Bit 2 latches on `sev_err_ev_i`, bit 1 on `tx_slip_ev_i` and bit 0 on `rx_slip_ev_i`.
- R4: Word one bit 7 latches on `fbit_err_ev_i`. Bit 6 latches on `crc_err_ev_i`, bit 4 on `realign_ev_i`, bit 3 on `bpv_ev_i`, bit 2 on `prbs_err_ev_i` and bit 1 on `density_ev_i`.
- R5: A bit latches only when its bit in `irq_en0_i` or `irq_en1_i` is 1 in the cycle of the source.
- R6: Clearing an enable bit does not clear the latched bit. Setting the enable again re-exposes the bit on `irq_o`.
- R7: A cycle with `rd_en_i` high clears, at that clock edge, the word chosen by `rd_sel_i`. A value of 0 chooses word zero and 1 chooses word one. The other word is unchanged.
- R8: A source that fires in the same cycle as the read that clears its word leaves its bit set after the read.
- R9: A framing bit error pulse latches only while `term_sync_i` is high in that cycle.
- R10: Word one bits 5 and 0 are unused. They always read 0 and never latch.
- R11: `irq_o` is 1 exactly when some latched bit in either word has its enable bit set.
- R12: `rd_data_o` shows the selected word, before any clear, while `rd_en_i` is high. It is 0 while `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| term_sync_i | input | 1 | Terminal frame sync level |
| mfrm_sync_i | input | 1 | Multiframe sync level |
| ais_i | input | 1 | Received all-ones level |
| los_i | input | 1 | Loss of signal level |
| yellow_ev_i | input | 1 | Yellow alarm detect pulse |
| sev_err_ev_i | input | 1 | Severely errored frame pulse |
| tx_slip_ev_i | input | 1 | Transmit buffer slip pulse |
| rx_slip_ev_i | input | 1 | Receive buffer slip pulse |
| fbit_err_ev_i | input | 1 | Framing bit error pulse |
| crc_err_ev_i | input | 1 | CRC-6 error pulse |
| realign_ev_i | input | 1 | Frame alignment moved after reframe |
| bpv_ev_i | input | 1 | Bipolar violation pulse |
| prbs_err_ev_i | input | 1 | PRBS check error pulse |
| density_ev_i | input | 1 | Pulse density violation pulse |
| irq_en0_i | input | 8 | Enables for word zero, 1 = may latch |
| irq_en1_i | input | 8 | Enables for word one, 1 = may latch |
| rd_en_i | input | 1 | Read strobe, clears the selected word |
| rd_sel_i | input | 1 | Word select, 0 = word zero, 1 = word one |
| rd_data_o | output | 8 | Read data |
| irq_o | output | 1 | Summary interrupt, active high |

## Verification
The checker covers several rules on every cycle: the unused bits stay zero, a bit never rises without its enable, a latched bit is kept unless its own word is read, a read of word one empties all bits with no fresh source, a gated framing error cannot appear without terminal sync, a colliding CRC event survives its read, and `irq_o` is consistent with the latched state. Some behaviour can only be shown by the bench scenarios. These are the exact bit positions of every source, latching on both rising and falling level changes, re-exposure after re-enabling, independence of the two words and clearing by reset partway through a run.

// File: rtl/framer_irq_pkg.sv
package framer_irq_pkg;

  localparam int IRQ_W   = 8;
  localparam int N_LEVEL = 4;

  // word zero bit positions
  localparam int W0_TSYNC = 7;
  localparam int W0_MSYNC = 6;
  localparam int W0_YEL   = 5;
  localparam int W0_AIS   = 4;
  localparam int W0_LOS   = 3;
  localparam int W0_SEF   = 2;
  localparam int W0_TXSLP = 1;
  localparam int W0_RXSLP = 0;

  // word one bit positions
  localparam int W1_FBIT  = 7;
  localparam int W1_CRC   = 6;
  localparam int W1_ALIGN = 4;
  localparam int W1_BPV   = 3;
  localparam int W1_PRBS  = 2;
  localparam int W1_DENS  = 1;

  localparam logic [IRQ_W-1:0] W0_USED = 8'hFF;
  localparam logic [IRQ_W-1:0] W1_USED = 8'b1101_1110;

  typedef logic [IRQ_W-1:0] irq_word_t;

endpackage

// File: rtl/irq_lvl_chg.sv
module irq_lvl_chg #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] chg_o
);

  logic [N-1:0] hist_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic hist_d;
    logic hist_ce;

    always_comb begin
      hist_ce  = lvl_i[g] ^ hist_q[g];
      hist_d   = lvl_i[g];
      chg_o[g] = hist_ce;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist_q[g] <= 1'b0;
      end else if (hist_ce) begin
        hist_q[g] <= hist_d;
      end
    end
  end

endmodule

// File: rtl/irq_sticky_word.sv
module irq_sticky_word #(
  parameter int              W    = 8,
  parameter logic [W-1:0]    USED = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] en_i,
  input  logic         clr_i,
  output logic [W-1:0] word_o,
  output logic         pend_o
);

  logic [W-1:0] word_q;
  logic [W-1:0] word_d;
  logic [W-1:0] set_v;
  logic         word_ce;

  always_comb begin
    set_v   = src_i & en_i & USED;
    word_ce = clr_i | (|set_v);
    if (clr_i) begin
      word_d = set_v;
    end else begin
      word_d = word_q | set_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_ce) begin
      word_q <= word_d;
    end
  end

  always_comb begin
    word_o = word_q;
    pend_o = |(word_q & en_i);
  end

endmodule

// File: rtl/framer_irq_regs.sv
module framer_irq_regs
  import framer_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             term_sync_i,
  input  logic             mfrm_sync_i,
  input  logic             ais_i,
  input  logic             los_i,
  input  logic             yellow_ev_i,
  input  logic             sev_err_ev_i,
  input  logic             tx_slip_ev_i,
  input  logic             rx_slip_ev_i,
  input  logic             fbit_err_ev_i,
  input  logic             crc_err_ev_i,
  input  logic             realign_ev_i,
  input  logic             bpv_ev_i,
  input  logic             prbs_err_ev_i,
  input  logic             density_ev_i,
  input  logic [IRQ_W-1:0] irq_en0_i,
  input  logic [IRQ_W-1:0] irq_en1_i,
  input  logic             rd_en_i,
  input  logic             rd_sel_i,
  output logic [IRQ_W-1:0] rd_data_o,
  output logic             irq_o
);

  logic [N_LEVEL-1:0] lvl_v;
  logic [N_LEVEL-1:0] chg_v;
  irq_word_t          src0;
  irq_word_t          src1;
  irq_word_t          word0_q;
  irq_word_t          word1_q;
  logic               pend0;
  logic               pend1;
  logic               clr0;
  logic               clr1;

  assign lvl_v = {term_sync_i, mfrm_sync_i, ais_i, los_i};

  irq_lvl_chg #(.N(N_LEVEL)) u_chg (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (lvl_v),
    .chg_o (chg_v)
  );

  always_comb begin
    src0            = '0;
    src0[W0_TSYNC]  = chg_v[3];
    src0[W0_MSYNC]  = chg_v[2];
    src0[W0_AIS]    = chg_v[1];
    src0[W0_LOS]    = chg_v[0];
    src0[W0_YEL]    = yellow_ev_i;
    src0[W0_SEF]    = sev_err_ev_i;
    src0[W0_TXSLP]  = tx_slip_ev_i;
    src0[W0_RXSLP]  = rx_slip_ev_i;

    src1            = '0;
    src1[W1_FBIT]   = fbit_err_ev_i & term_sync_i;
    src1[W1_CRC]    = crc_err_ev_i;
    src1[W1_ALIGN]  = realign_ev_i;
    src1[W1_BPV]    = bpv_ev_i;
    src1[W1_PRBS]   = prbs_err_ev_i;
    src1[W1_DENS]   = density_ev_i;

    clr0 = rd_en_i & ~rd_sel_i;
    clr1 = rd_en_i &  rd_sel_i;
  end

  irq_sticky_word #(.W(IRQ_W), .USED(W0_USED)) u_word0 (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src0),
    .en_i   (irq_en0_i),
    .clr_i  (clr0),
    .word_o (word0_q),
    .pend_o (pend0)
  );

  irq_sticky_word #(.W(IRQ_W), .USED(W1_USED)) u_word1 (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src1),
    .en_i   (irq_en1_i),
    .clr_i  (clr1),
    .word_o (word1_q),
    .pend_o (pend1)
  );

  always_comb begin
    if (!rd_en_i) begin
      rd_data_o = '0;
    end else if (rd_sel_i) begin
      rd_data_o = word1_q;
    end else begin
      rd_data_o = word0_q;
    end
    irq_o = pend0 | pend1;
  end

endmodule

// File: rtl/framer_irq_chk.sv
module framer_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] w0,
  input logic [7:0] w1,
  input logic [7:0] en0,
  input logic [7:0] en1,
  input logic       rd_en,
  input logic       rd_sel,
  input logic       term_sync,
  input logic [7:0] ev1,
  input logic       irq
);

  // R10
  unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (w1[5] == 1'b0) && (w1[0] == 1'b0));

  // R5
  en0_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en0 != 8'hFF) |=> ((w0 & ~$past(w0) & ~$past(en0)) == 8'h00));

  // R5
  en1_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en1 != 8'hFF) |=> ((w1 & ~$past(w1) & ~$past(en1)) == 8'h00));

  // R6
  hold0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && !rd_sel) |=> (($past(w0) & ~w0) == 8'h00));

  // R7
  clear1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel) |=> ((w1 & ~$past(ev1)) == 8'h00));

  // R8
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_sel && ev1[6] && en1[6]) |=> w1[6]);

  // R9
  fbit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!term_sync && !w1[7]) |=> !w1[7]);

  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((w0 | w1) != 8'h00));

  // R11
  irq_all_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((en0 == 8'hFF) && (en1 == 8'hFF) && ((w0 | w1) != 8'h00)) |-> irq);

endmodule

bind framer_irq_regs framer_irq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .w0        (word0_q),
  .w1        (word1_q),
  .en0       (irq_en0_i),
  .en1       (irq_en1_i),
  .rd_en     (rd_en_i),
  .rd_sel    (rd_sel_i),
  .term_sync (term_sync_i),
  .ev1       ({fbit_err_ev_i, crc_err_ev_i, 1'b0, realign_ev_i,
               bpv_ev_i, prbs_err_ev_i, density_ev_i, 1'b0}),
  .irq       (irq_o)
);

// File: tb/framer_irq_regs_tb.sv
module framer_irq_regs_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] lvl = 4'b0;
  logic [9:0] ev = 10'b0;
  logic [7:0] en0 = 8'hFF;
  logic [7:0] en1 = 8'hFF;
  logic       rd_en = 1'b0;
  logic       rd_sel = 1'b0;
  logic [7:0] rd_data;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  framer_irq_regs u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .term_sync_i   (lvl[3]),
    .mfrm_sync_i   (lvl[2]),
    .ais_i         (lvl[1]),
    .los_i         (lvl[0]),
    .yellow_ev_i   (ev[9]),
    .sev_err_ev_i  (ev[8]),
    .tx_slip_ev_i  (ev[7]),
    .rx_slip_ev_i  (ev[6]),
    .fbit_err_ev_i (ev[5]),
    .crc_err_ev_i  (ev[4]),
    .realign_ev_i  (ev[3]),
    .bpv_ev_i      (ev[2]),
    .prbs_err_ev_i (ev[1]),
    .density_ev_i  (ev[0]),
    .irq_en0_i     (en0),
    .irq_en1_i     (en1),
    .rd_en_i       (rd_en),
    .rd_sel_i      (rd_sel),
    .rd_data_o     (rd_data),
    .irq_o         (irq)
  );

  // {levels ts,mf,ais,los | events yel,sef,txs,rxs,fbe,crc,cofa,bpv,prbs,pdv | exp0 | exp1 | irq}
  localparam logic [30:0] VECS [0:10] = '{
    {4'b1000, 10'b00_0000_0000, 8'h80, 8'h00, 1'b1},
    {4'b1100, 10'b10_0000_0000, 8'h60, 8'h00, 1'b1},
    {4'b1110, 10'b00_0100_0000, 8'h11, 8'h00, 1'b1},
    {4'b1111, 10'b01_1000_0000, 8'h0E, 8'h00, 1'b1},
    {4'b1111, 10'b00_0010_0000, 8'h00, 8'h80, 1'b1},
    {4'b1111, 10'b00_0001_1000, 8'h00, 8'h50, 1'b1},
    {4'b1111, 10'b00_0000_0111, 8'h00, 8'h0E, 1'b1},
    {4'b0111, 10'b00_0010_0000, 8'h80, 8'h00, 1'b1},
    {4'b0000, 10'b00_0000_0000, 8'h58, 8'h00, 1'b1},
    {4'b0000, 10'b11_1111_1111, 8'h27, 8'h5E, 1'b1},
    {4'b0000, 10'b00_0000_0000, 8'h00, 8'h00, 1'b0}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // read a word: data sampled before the clearing edge
  task automatic rd_word(input logic sel, input string tag, input logic [7:0] exp);
    rd_en  = 1'b1;
    rd_sel = sel;
    #1;
    check(tag, rd_data, exp);
    tick();
    rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [9:0] e);
    ev = e;
    tick();
    ev = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1 irq in reset", {7'b0, irq}, 8'h00);
    rst_n = 1'b1;
    tick();
    check("R1 irq after reset", {7'b0, irq}, 8'h00);
    rd_word(1'b0, "R1 word0 after reset", 8'h00);
    rd_word(1'b1, "R1 word1 after reset", 8'h00);

    // vector table: R2 R3 R4 R9 R10 R11
    foreach (VECS[i]) begin
      lvl = VECS[i][30:27];
      pulse(VECS[i][26:17]);
      check($sformatf("R11 irq vec%0d", i), {7'b0, irq}, {7'b0, VECS[i][0]});
      rd_word(1'b0, $sformatf("R2/R3 word0 vec%0d", i), VECS[i][16:9]);
      rd_word(1'b1, $sformatf("R4/R9/R10 word1 vec%0d", i), VECS[i][8:1]);
    end

    // R5 disabled source does not latch
    en0 = 8'h00;
    pulse(10'b10_0000_0000);
    en0 = 8'hFF;
    check("R5 irq masked source", {7'b0, irq}, 8'h00);
    rd_word(1'b0, "R5 word0 masked source", 8'h00);

    // R6 mask hides but keeps
    pulse(10'b00_0001_0000);
    check("R6 irq latched", {7'b0, irq}, 8'h01);
    en1 = 8'h00;
    #1;
    check("R6 irq hidden", {7'b0, irq}, 8'h00);
    tick();
    en1 = 8'hFF;
    #1;
    check("R6 irq re-exposed", {7'b0, irq}, 8'h01);
    // R12 read data zero when idle
    check("R12 rd_data idle", rd_data, 8'h00);
    rd_word(1'b1, "R6 word1 kept", 8'h40);

    // R7 independent clear; R8 collision
    pulse(10'b10_0001_0000);
    rd_en = 1'b1;
    rd_sel = 1'b1;
    ev = 10'b00_0001_0000;
    #1;
    check("R12 rd_data word1", rd_data, 8'h40);
    tick();
    ev = '0;
    rd_en = 1'b0;
    rd_word(1'b1, "R8 word1 collision kept", 8'h40);
    rd_word(1'b1, "R7 word1 cleared", 8'h00);
    rd_word(1'b0, "R7 word0 untouched", 8'h20);

    // R1 reset mid-run clears everything
    pulse(10'b11_1111_1111);
    rst_n = 1'b0;
    #1;
    check("R1 irq mid reset", {7'b0, irq}, 8'h00);
    tick();
    rst_n = 1'b1;
    tick();
    rd_word(1'b0, "R1 word0 post reset", 8'h00);
    rd_word(1'b1, "R1 word1 post reset", 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule